// File: doc/BRIEF.md
# USB Endpoint Transmit Buffer Engine

This block serves the device side of a USB function core whenever the host asks an endpoint for data. When an IN token event names an endpoint whose transmit status is valid, it looks up that endpoint's buffer descriptor in a 16-bit packet memory. The descriptor holds a start address and a byte count. The block then streams the stored payload, one byte at a time, behind a DATA0 or DATA1 PID, and closes the packet with a CRC16. No software takes part in the sequence.

If the endpoint is stalled or has nothing ready, the block emits a single STALL or NAK handshake byte on the same stream instead. When a data packet's last CRC byte is taken, the block pulses a completion strobe with the endpoint number, so firmware can refill that endpoint's buffer. The block leaves the data toggle alone, because the toggle is owned by the handshake logic.

Top module: `usbtx_engine`

## Requirements
- R1: After reset, tx_valid, tx_done and mem_rd_en are all low.
- R2: A token to an endpoint whose status code is 2'b00 (disabled) produces no output byte, no memory read and no completion pulse.
- R3: Status 2'b01 answers a token with the single byte 0x1E (STALL), and status 2'b10 answers with the single byte 0x5A (NAK). In both cases tx_last is high on that byte, no memory read occurs and no completion pulse follows.
- R4: Status 2'b11 starts a data packet. The memory reads begin at word address DESC_BASE+4*ep, which holds the start byte address, and continue at DESC_BASE+4*ep+1, which holds the count in bits [CNT_W-1:0]. Count bits above CNT_W are ignored. Packet memory has a one-cycle read latency.
- R5: The first byte of a data packet is 0xC3 (DATA0) when the endpoint's toggle input is 0, and 0x4B (DATA1) when it is 1.
- R6: Payload bytes follow the PID in order. Each 16-bit word gives its low byte first and then its high byte. Words are read at word address (start>>1), then +1, +2 and so on, with bit 0 of the start address ignored. Exactly ceil(count/2) payload words are read, and an odd count sends only the low byte of the final word.
- R7: Two CRC bytes follow the payload. The CRC uses polynomial x^16+x^15+x^2+1, starts from 0xFFFF, processes each byte LSB first, and is sent complemented with the low byte first. An empty payload gives 0x00 0x00. tx_last is high only on the final CRC byte.
- R8: While tx_valid is high and tx_ready is low, tx_valid, tx_data and tx_last stay unchanged into the next cycle.
- R9: One cycle after the final CRC byte is accepted, tx_done is high for exactly one cycle, and tx_done_ep carries the endpoint number.
- R10: Token events that arrive while a response is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_valid | input | 1 | One-cycle IN token event |
| tok_ep | input | EP_W | Endpoint addressed by the token |
| ep_stat | input | 2*2**EP_W | Per-endpoint transmit status, two bits per endpoint |
| ep_tog | input | 2**EP_W | Per-endpoint transmit data toggle |
| mem_rd_en | output | 1 | Packet memory read strobe |
| mem_rd_addr | output | MEM_AW | Packet memory word address |
| mem_rd_data | input | 16 | Read data, valid one cycle after the strobe |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of the packet |
| tx_done | output | 1 | Data packet completed (one-cycle pulse) |
| tx_done_ep | output | EP_W | Endpoint of the completed packet |

## Verification
The hardest case to reach from the ports is a payload word that arrives from memory at the same edge the consumer accepts the high byte of the previous word, compared with the case where the word must wait in the spare register. Both depend on how tx_ready toggles around each word boundary. The bench drives tx_ready from a free-running LFSR during long odd and even payloads, so both timings occur many times. Every byte, including the CRC, is compared against a queue that the bench builds from its own CRC model and payload pattern.

// File: rtl/usbtx_pkg.sv
package usbtx_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DADDR,
    ST_DCNT,
    ST_FIRST,
    ST_PID,
    ST_DATA,
    ST_CRCL,
    ST_CRCH,
    ST_HS
  } tx_state_t;

  localparam logic [1:0] STAT_OFF   = 2'b00;
  localparam logic [1:0] STAT_STALL = 2'b01;
  localparam logic [1:0] STAT_NAK   = 2'b10;
  localparam logic [1:0] STAT_VALID = 2'b11;

  localparam logic [7:0] PID_DATA0 = 8'hC3;
  localparam logic [7:0] PID_DATA1 = 8'h4B;
  localparam logic [7:0] PID_NAK   = 8'h5A;
  localparam logic [7:0] PID_STALL = 8'h1E;

  // Reflected CRC16 step over one byte, LSB first.
  function automatic logic [15:0] crc16_step(input logic [15:0] crc, input logic [7:0] b);
    logic [15:0] c;
    c = crc;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ b[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

  function automatic logic [7:0] data_pid(input logic tog);
    return tog ? PID_DATA1 : PID_DATA0;
  endfunction

  function automatic logic [7:0] hs_pid(input logic [1:0] stat);
    return (stat == STAT_STALL) ? PID_STALL : PID_NAK;
  endfunction

endpackage

// File: rtl/usbtx_crc16.sv
module usbtx_crc16
  import usbtx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [7:0]  din,
  output logic [15:0] crc_out
);

  logic [15:0] crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)   crc_q <= 16'hFFFF;
    else if (clr) crc_q <= 16'hFFFF;
    else if (upd) crc_q <= crc16_step(crc_q, din);
  end

  assign crc_out = ~crc_q;

  // R7: freshly cleared accumulator yields the empty-payload CRC
  a_r7_empty_crc: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> crc_out == 16'h0000);

endmodule

// File: rtl/usbtx_wordbuf.sv
module usbtx_wordbuf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic [15:0] rd_data,
  input  logic        load,
  input  logic        hi_sel,
  output logic [7:0]  byte_out
);

  logic        cap_q;
  logic        have_q;
  logic [15:0] nxt_q;
  logic [15:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_q  <= 1'b0;
      have_q <= 1'b0;
      nxt_q  <= '0;
      word_q <= '0;
    end else begin
      cap_q <= issue;
      if (load) begin
        word_q <= cap_q ? rd_data : nxt_q;
        have_q <= 1'b0;
      end else if (cap_q) begin
        nxt_q  <= rd_data;
        have_q <= 1'b1;
      end
    end
  end

  assign byte_out = hi_sel ? word_q[15:8] : word_q[7:0];

  // R6: a word is only consumed once it has arrived from memory
  a_r6_load_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (cap_q || have_q));

  // R6: an arriving word never overwrites an unconsumed one
  a_r6_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q && !load) |-> !have_q);

endmodule

// File: rtl/usbtx_ctrl.sv
module usbtx_ctrl
  import usbtx_pkg::*;
#(
  parameter int EP_W      = 3,
  parameter int MEM_AW    = 9,
  parameter int CNT_W     = 10,
  parameter int DESC_BASE = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tok_valid,
  input  logic [EP_W-1:0]         tok_ep,
  input  logic [2*(1<<EP_W)-1:0]  ep_stat,
  input  logic [(1<<EP_W)-1:0]    ep_tog,
  output logic                    mem_rd_en,
  output logic [MEM_AW-1:0]       mem_rd_addr,
  input  logic [15:0]             mem_rd_data,
  input  logic                    tx_ready,
  output logic                    tx_valid,
  output logic                    tx_last,
  output tx_state_t               state,
  output logic [7:0]              pid,
  output logic                    hi_sel,
  output logic                    buf_issue,
  output logic                    buf_load,
  output logic                    crc_clr,
  output logic                    crc_upd,
  output logic                    done,
  output logic [EP_W-1:0]         done_ep
);

  tx_state_t         state_q, state_d;
  logic [EP_W-1:0]   ep_q, ep_d;
  logic [7:0]        pid_q, pid_d;
  logic [15:0]       addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic              hi_q, hi_d;
  logic              done_q;
  logic [EP_W-1:0]   done_ep_q;

  logic [1:0]        tok_stat;
  logic              accept;
  logic              last_ack;
  logic [MEM_AW-1:0] desc_a;
  logic [15:0]       addr_nx;
  logic              unused_bits;

  assign tok_stat    = ep_stat[{tok_ep, 1'b0} +: 2];
  assign tx_valid    = (state_q == ST_PID) || (state_q == ST_DATA) || (state_q == ST_CRCL) ||
                       (state_q == ST_CRCH) || (state_q == ST_HS);
  assign tx_last     = (state_q == ST_CRCH) || (state_q == ST_HS);
  assign accept      = tx_valid && tx_ready;
  assign last_ack    = (state_q == ST_CRCH) && tx_ready;
  assign desc_a      = MEM_AW'(DESC_BASE) + MEM_AW'({ep_q, 2'b00});
  assign addr_nx     = addr_q + 16'd2;
  assign unused_bits = ^{addr_q[15:MEM_AW+1], addr_q[0], addr_nx[15:MEM_AW+1], addr_nx[0]};

  always_comb begin
    state_d     = state_q;
    ep_d        = ep_q;
    pid_d       = pid_q;
    addr_d      = addr_q;
    rem_d       = rem_q;
    hi_d        = hi_q;
    mem_rd_en   = 1'b0;
    mem_rd_addr = '0;
    buf_issue   = 1'b0;
    buf_load    = 1'b0;
    crc_clr     = 1'b0;
    crc_upd     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (tok_valid && tok_stat != STAT_OFF) begin
          ep_d = tok_ep;
          if (tok_stat == STAT_VALID) begin
            pid_d   = data_pid(ep_tog[tok_ep]);
            crc_clr = 1'b1;
            state_d = ST_DADDR;
          end else begin
            pid_d   = hs_pid(tok_stat);
            state_d = ST_HS;
          end
        end
      end
      ST_DADDR: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = desc_a;
        state_d     = ST_DCNT;
      end
      ST_DCNT: begin
        mem_rd_en   = 1'b1;
        mem_rd_addr = desc_a + MEM_AW'(1);
        addr_d      = mem_rd_data;
        state_d     = ST_FIRST;
      end
      ST_FIRST: begin
        rem_d       = mem_rd_data[CNT_W-1:0];
        mem_rd_en   = |mem_rd_data[CNT_W-1:0];
        buf_issue   = mem_rd_en;
        mem_rd_addr = addr_q[MEM_AW:1];
        hi_d        = 1'b0;
        state_d     = ST_PID;
      end
      ST_PID: begin
        if (tx_ready) begin
          if (rem_q == '0) begin
            state_d = ST_CRCL;
          end else begin
            buf_load = 1'b1;
            state_d  = ST_DATA;
          end
        end
      end
      ST_DATA: begin
        if (tx_ready) begin
          crc_upd = 1'b1;
          rem_d   = rem_q - CNT_W'(1);
          if (rem_q == CNT_W'(1)) begin
            state_d = ST_CRCL;
          end else if (!hi_q) begin
            hi_d = 1'b1;
            if (rem_q > CNT_W'(2)) begin
              mem_rd_en   = 1'b1;
              buf_issue   = 1'b1;
              mem_rd_addr = addr_nx[MEM_AW:1];
            end
          end else begin
            hi_d     = 1'b0;
            buf_load = 1'b1;
            addr_d   = addr_nx;
          end
        end
      end
      ST_CRCL: if (tx_ready) state_d = ST_CRCH;
      ST_CRCH: if (tx_ready) state_d = ST_IDLE;
      ST_HS:   if (tx_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ep_q      <= '0;
      pid_q     <= '0;
      addr_q    <= '0;
      rem_q     <= '0;
      hi_q      <= 1'b0;
      done_q    <= 1'b0;
      done_ep_q <= '0;
    end else begin
      state_q   <= state_d;
      ep_q      <= ep_d;
      pid_q     <= pid_d;
      addr_q    <= addr_d;
      rem_q     <= rem_d;
      hi_q      <= hi_d;
      done_q    <= last_ack;
      if (last_ack) done_ep_q <= ep_q;
    end
  end

  assign state   = state_q;
  assign pid     = pid_q;
  assign hi_sel  = hi_q;
  assign done    = done_q;
  assign done_ep = done_ep_q;

  // R2: no memory traffic while waiting for a token
  a_r2_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !mem_rd_en);

  // R3: a handshake is one byte, then back to idle with no completion pulse
  a_r3_hs_single: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HS && tx_ready) |=> (state_q == ST_IDLE && !done_q && !mem_rd_en));

  // R4: descriptor count word is read right after the address word
  a_r4_desc_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DADDR) |=> (mem_rd_en && mem_rd_addr == $past(mem_rd_addr) + MEM_AW'(1)));

  // R8: a stalled byte keeps its framing
  a_r8_hold_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_last) && $stable(state_q)));

  // R9: completion is a single-cycle pulse
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R10: a token during a response does not restart the sequence
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && tok_valid) |=> $stable(ep_q));

endmodule

// File: rtl/usbtx_engine.sv
module usbtx_engine
  import usbtx_pkg::*;
#(
  parameter int EP_W      = 3,
  parameter int MEM_AW    = 9,
  parameter int CNT_W     = 10,
  parameter int DESC_BASE = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tok_valid,
  input  logic [EP_W-1:0]         tok_ep,
  input  logic [2*(1<<EP_W)-1:0]  ep_stat,
  input  logic [(1<<EP_W)-1:0]    ep_tog,
  output logic                    mem_rd_en,
  output logic [MEM_AW-1:0]       mem_rd_addr,
  input  logic [15:0]             mem_rd_data,
  output logic                    tx_valid,
  input  logic                    tx_ready,
  output logic [7:0]              tx_data,
  output logic                    tx_last,
  output logic                    tx_done,
  output logic [EP_W-1:0]         tx_done_ep
);

  tx_state_t   st;
  logic [7:0]  pid;
  logic        hi_sel;
  logic        buf_issue;
  logic        buf_load;
  logic        crc_clr;
  logic        crc_upd;
  logic [7:0]  pay_byte;
  logic [15:0] crc_val;

  usbtx_ctrl #(
    .EP_W(EP_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .DESC_BASE(DESC_BASE)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .tok_valid(tok_valid), .tok_ep(tok_ep), .ep_stat(ep_stat), .ep_tog(ep_tog),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_last(tx_last),
    .state(st), .pid(pid), .hi_sel(hi_sel),
    .buf_issue(buf_issue), .buf_load(buf_load),
    .crc_clr(crc_clr), .crc_upd(crc_upd),
    .done(tx_done), .done_ep(tx_done_ep)
  );

  usbtx_wordbuf u_buf (
    .clk(clk), .rst_n(rst_n),
    .issue(buf_issue), .rd_data(mem_rd_data),
    .load(buf_load), .hi_sel(hi_sel), .byte_out(pay_byte)
  );

  usbtx_crc16 u_crc (
    .clk(clk), .rst_n(rst_n),
    .clr(crc_clr), .upd(crc_upd), .din(pay_byte), .crc_out(crc_val)
  );

  always_comb begin
    case (st)
      ST_PID, ST_HS: tx_data = pid;
      ST_DATA:       tx_data = pay_byte;
      ST_CRCL:       tx_data = crc_val[7:0];
      ST_CRCH:       tx_data = crc_val[15:8];
      default:       tx_data = 8'h00;
    endcase
  end

  // R8: the byte itself is held while the consumer stalls
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_data));

  // R7: after the closing byte the stream goes quiet
  a_r7_last_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !tx_valid);

endmodule

// File: tb/tb_usbtx_engine.sv
`timescale 1ns/1ps
module tb_usbtx_engine;
  localparam int EP_W = 3;
  localparam int NEP = 1 << EP_W;
  localparam int MEM_AW = 9;
  localparam int CNT_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tok_valid = 1'b0;
  logic [EP_W-1:0] tok_ep = '0;
  logic [2*NEP-1:0] ep_stat = '0;
  logic [NEP-1:0] ep_tog = '0;
  logic mem_rd_en;
  logic [MEM_AW-1:0] mem_rd_addr;
  logic [15:0] mem_rd_data = '0;
  logic tx_valid, tx_last, tx_done;
  logic tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic [EP_W-1:0] tx_done_ep;

  logic [15:0] mem [0:(1<<MEM_AW)-1];
  logic [7:0] lf = 8'hA5;
  bit rdy_rand = 0;

  logic [8:0] exp_q[$];
  int rd_q[$];
  int checks = 0, fails = 0, done_cnt = 0, done_ep_seen = 0;
  string cur_req = "R1";
  bit hold_v = 0;
  logic [7:0] hold_d;
  logic hold_l;

  usbtx_engine #(.EP_W(EP_W), .MEM_AW(MEM_AW), .CNT_W(CNT_W), .DESC_BASE(0)) dut (
    .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_ep(tok_ep),
    .ep_stat(ep_stat), .ep_tog(ep_tog), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_done(tx_done), .tx_done_ep(tx_done_ep));

  always #2 clk = ~clk;

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];

  always @(posedge clk) begin
    #1;
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    tx_ready <= rst_n && (rdy_rand ? (lf[0] | lf[2]) : 1'b1);
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard as bytes are accepted
  initial forever begin
    @(negedge clk);
    if (rst_n) begin
      if (mem_rd_en) rd_q.push_back(int'(mem_rd_addr));
      if (tx_done) begin done_cnt++; done_ep_seen = int'(tx_done_ep); end
      if (hold_v) begin
        chk(tx_valid && tx_data == hold_d && tx_last == hold_l, "R8", "stalled byte held",
            int'({tx_valid, tx_last, tx_data}), int'({1'b1, hold_l, hold_d}));
        hold_v = 0;
      end
      if (tx_valid && tx_ready) begin
        if (exp_q.size() == 0) begin
          chk(0, cur_req, "unexpected byte", int'({tx_last, tx_data}), 0);
        end else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          chk({tx_last, tx_data} == e, cur_req, "stream byte", int'({tx_last, tx_data}), int'(e));
        end
      end else if (tx_valid) begin
        hold_v = 1; hold_d = tx_data; hold_l = tx_last;
      end
    end
  end

  function automatic logic [15:0] pay_word(input int seed, input int i);
    return {8'(seed * 7 + 2 * i + 1), 8'(seed * 13 + 2 * i + 5)};
  endfunction

  task automatic run_pkt(input int ep, input logic [1:0] stat, input bit tog, input int saddr,
                         input int cnt, input int seed, input bit stray, input string req);
    logic [15:0] r;
    logic [15:0] rr;
    int nwords, d0, base;
    cur_req = req;
    base = (saddr >> 1);
    mem[ep * 4] = 16'(saddr);
    mem[ep * 4 + 1] = 16'(cnt) | 16'hFC00;
    nwords = (cnt + 1) / 2;
    for (int w = 0; w < nwords; w++) mem[base + w] = pay_word(seed, w);
    ep_stat[ep * 2 +: 2] = stat;
    ep_tog[ep] = tog;
    if (stat == 2'b01) exp_q.push_back({1'b1, 8'h1E});
    if (stat == 2'b10) exp_q.push_back({1'b1, 8'h5A});
    if (stat == 2'b11) begin
      exp_q.push_back({1'b0, tog ? 8'h4B : 8'hC3});
      r = 16'hFFFF;
      for (int k = 0; k < cnt; k++) begin
        logic [15:0] wv;
        logic [7:0] b;
        wv = pay_word(seed, k / 2);
        b = (k % 2 == 0) ? wv[7:0] : wv[15:8];
        exp_q.push_back({1'b0, b});
        for (int j = 0; j < 8; j++) begin
          logic fb;
          fb = r[15] ^ b[j];
          r = {r[14:0], 1'b0} ^ (fb ? 16'h8005 : 16'h0000);
        end
      end
      for (int j = 0; j < 16; j++) rr[j] = r[15 - j];
      rr = ~rr;
      exp_q.push_back({1'b0, rr[7:0]});
      exp_q.push_back({1'b1, rr[15:8]});
    end
    rd_q.delete();
    d0 = done_cnt;
    @(negedge clk);
    tok_valid = 1'b1; tok_ep = EP_W'(ep);
    @(negedge clk);
    tok_valid = 1'b0;
    if (stray) begin
      repeat (6) @(negedge clk);
      tok_valid = 1'b1; tok_ep = '0;
      @(negedge clk);
      tok_valid = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    if (stat == 2'b11) begin
      chk(rd_q.size() == 2 + nwords, "R6", "read count", rd_q.size(), 2 + nwords);
      if (rd_q.size() == 2 + nwords) begin
        chk(rd_q[0] == ep * 4, "R4", "descriptor addr word", rd_q[0], ep * 4);
        chk(rd_q[1] == ep * 4 + 1, "R4", "descriptor count word", rd_q[1], ep * 4 + 1);
        for (int w = 0; w < nwords; w++)
          chk(rd_q[2 + w] == base + w, "R6", "payload word addr", rd_q[2 + w], base + w);
      end
      chk(done_cnt - d0 == 1, "R9", "done pulses", done_cnt - d0, 1);
      chk(done_ep_seen == ep, "R9", "done endpoint", done_ep_seen, ep);
    end else begin
      chk(rd_q.size() == 0, stat == 2'b00 ? "R2" : "R3", "no memory reads", rd_q.size(), 0);
      chk(done_cnt == d0, stat == 2'b00 ? "R2" : "R3", "no done pulse", done_cnt - d0, 0);
    end
    chk(!tx_valid, req, "stream idle afterwards", int'(tx_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1 << MEM_AW); i++) mem[i] = 16'h0;
    repeat (4) @(negedge clk);
    chk(!tx_valid && !tx_done && !mem_rd_en, "R1", "outputs in reset",
        int'({tx_valid, tx_done, mem_rd_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!tx_valid && !tx_done && !mem_rd_en, "R1", "outputs after reset",
        int'({tx_valid, tx_done, mem_rd_en}), 0);
    // endpoint 0 answers NAK if a stray token were ever taken (R10)
    ep_stat[1:0] = 2'b10;

    run_pkt(3, 2'b11, 1'b0, 16'h0040, 4, 1, 0, "R5");   // DATA0, even count
    run_pkt(5, 2'b11, 1'b1, 16'h0080, 7, 2, 0, "R6");   // DATA1, odd count
    run_pkt(1, 2'b11, 1'b0, 16'h00A0, 0, 3, 0, "R7");   // empty payload: CRC 00 00
    run_pkt(2, 2'b11, 1'b1, 16'h00B0, 1, 4, 0, "R6");   // single byte
    run_pkt(7, 2'b11, 1'b0, 16'h00C1, 6, 5, 0, "R4");   // start bit0 ignored, count high bits ignored
    run_pkt(4, 2'b01, 1'b0, 16'h0040, 4, 6, 0, "R3");   // STALL
    run_pkt(4, 2'b10, 1'b0, 16'h0040, 4, 6, 0, "R3");   // NAK
    run_pkt(6, 2'b00, 1'b0, 16'h0040, 4, 6, 0, "R2");   // disabled endpoint
    rdy_rand = 1;
    run_pkt(3, 2'b11, 1'b1, 16'h0100, 64, 7, 1, "R10"); // stall pattern plus stray token
    run_pkt(5, 2'b11, 1'b0, 16'h0180, 33, 8, 0, "R8");
    run_pkt(2, 2'b11, 1'b1, 16'h0200, 2, 9, 1, "R10");
    run_pkt(4, 2'b10, 1'b0, 16'h0040, 0, 0, 0, "R3");
    rdy_rand = 0;
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule